// File: doc/BRIEF.md
# Private-Cache Line Coherence Controller

This block is the coherence state machine for one line of a private cache in a three-state (Modified, Shared, Invalid) directory system. It takes load, store and evict requests from the processor and messages from the network. It answers with requests to the home directory, data replies, invalidation acknowledgements, and a hit or stall indication back to the processor. The data array, the network and the directory sit outside the block. The block only decides permissions, message traffic and the order of events.

A line moves between three stable states through transient states. These transient states absorb races between the line's own requests and traffic from other caches. While a store miss is outstanding, the block counts invalidation acknowledgements against the count carried by the data reply. A forwarded request that arrives during that wait is held back until one store has completed. A dirty eviction waits for the home's acknowledgement. If a forwarded request overtakes that writeback, the block serves the requester and then keeps waiting in a state that no longer owns the line.

Only one message is accepted per cycle, and a message always takes precedence over the processor in that cycle. The processor holds its request until `cpu_hit` is seen.

States and their codes on `line_state`: I (0) invalid, S (1) shared, M (2) modified, IS_D (3) load miss awaiting data, IS_DI (4) load miss invalidated before data, IM_AD (5) store miss awaiting data, IM_A (6) data received with acknowledgements outstanding, MF (7) write permission held with one store owed before a deferred forward, MI_A (8) writeback awaiting acknowledgement, SI_A (9) writeback overtaken by a shared forward, II_A (10) writeback overtaken by an exclusive forward.

Transitions:
- I→IS_D on load (Get-S); I→IM_AD on store (Get-M).
- S→IM_AD on store (Get-M); S→I on evict or Inv.
- M→MI_A on evict (Put-M); M→S on Fwd-Get-S; M→I on Fwd-Get-M.
- IS_D→S on Data; IS_D→IS_DI on Inv; IS_DI→I on Data.
- IM_AD→M, IM_AD→MF or IM_AD→IM_A on Data; IM_A→M or IM_A→MF on the final Inv-Ack.
- MF→I or MF→S on the owed store.
- MI_A→SI_A on Fwd-Get-S; MI_A→II_A on Fwd-Get-M; MI_A, SI_A and II_A→I on Put-Ack.

Top module: `coh_line_ctrl`

## Requirements
- R1: After reset `line_state` is I (0), `tx_valid` is low and `cpu_hit` is low.
- R2: A load in I sends Get-S to the home and enters IS_D. Data in IS_D enters S. A load in S or M hits.
- R3: A store in I or S sends Get-M to the home, clears the acknowledgement counter and enters IM_AD.
- R4: Data in IM_AD adds its acknowledgement count to the counter, and each Inv-Ack in IM_AD or IM_A subtracts one. The counter may go below zero before Data arrives. Write permission is reached only once Data has arrived and the counter is zero, so Data with a count of zero that finds the counter at zero completes at once. Otherwise the line waits in IM_A.
- R5: A Fwd-Get-S or Fwd-Get-M that arrives in IM_AD or IM_A is held, and completion enters MF instead of M. In MF the processor's store hits, and in that same cycle Data goes to the held requester. For a held Fwd-Get-S the line enters S and `tx_home_copy` is high; for a held Fwd-Get-M the line enters I.
- R6: An evict in M sends Put-M to the home and enters MI_A. An evict in S hits and enters I. An evict in I hits.
- R7: In MI_A, Fwd-Get-S sends Data to the requester with `tx_home_copy` high and enters SI_A. Fwd-Get-M sends Data to the requester and enters II_A.
- R8: Put-Ack in MI_A, SI_A or II_A enters I.
- R9: In M, Fwd-Get-S sends Data to the requester with `tx_home_copy` high and enters S. Fwd-Get-M sends Data to the requester and enters I.
- R10: Inv in I, S, IS_D, IM_AD or IM_A sends Inv-Ack to the node named in `rx_src`. S goes to I, IS_D goes to IS_DI, and the other states keep their state. Data in IS_DI enters I without a hit.
- R11: A processor request stalls in every transient state except a store in MF, and in every cycle with `rx_valid` high. `cpu_stall` equals `cpu_valid` and not `cpu_hit`.
- R12: Message codes on `rx_type` and `tx_type` are Get-S 0, Get-M 1, Put-M 2, Data 3, Inv 4, Inv-Ack 5, Fwd-Get-S 6, Fwd-Get-M 7, Put-Ack 8. Processor operation codes are load 0, store 1, evict 2. State codes are those listed above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_valid | input | 1 | Processor request present |
| cpu_op | input | 2 | Load 0, store 1, evict 2 |
| cpu_hit | output | 1 | Request completes this cycle |
| cpu_stall | output | 1 | Request present but not completed |
| rx_valid | input | 1 | Incoming message present |
| rx_type | input | 4 | Incoming message code |
| rx_src | input | NODE_W | Requester or sender named by the message |
| rx_acks | input | ACK_W | Acknowledgement count carried by Data (signed) |
| tx_valid | output | 1 | Outgoing message present |
| tx_type | output | 4 | Outgoing message code |
| tx_dst | output | NODE_W | Destination node |
| tx_home_copy | output | 1 | Outgoing Data is also sent to the home |
| line_state | output | 4 | Current line state code |

## Verification
The assertions assume that the network and directory behave as a directory protocol does. Put-Ack arrives only after Put-M has been sent. Data and Inv-Ack arrive only for an outstanding miss. At most one forward arrives during a store miss. The processor holds a store in MF until it hits. The stimulus follows complete protocol exchanges, such as a miss followed by its reply and acknowledgements, or an eviction followed by a racing forward and its Put-Ack. It never sends a message that a real directory could not send in the current state, and it keeps the acknowledgement counter within a few units of zero.

// File: rtl/coh_line_pkg.sv
package coh_line_pkg;

    typedef enum logic [3:0] {
        LS_I    = 4'd0,
        LS_S    = 4'd1,
        LS_M    = 4'd2,
        LS_ISD  = 4'd3,
        LS_ISDI = 4'd4,
        LS_IMAD = 4'd5,
        LS_IMA  = 4'd6,
        LS_MF   = 4'd7,
        LS_MIA  = 4'd8,
        LS_SIA  = 4'd9,
        LS_IIA  = 4'd10
    } line_st_e;

    typedef enum logic [3:0] {
        MSG_GETS   = 4'd0,
        MSG_GETM   = 4'd1,
        MSG_PUTM   = 4'd2,
        MSG_DATA   = 4'd3,
        MSG_INV    = 4'd4,
        MSG_INVACK = 4'd5,
        MSG_FWDS   = 4'd6,
        MSG_FWDM   = 4'd7,
        MSG_PUTACK = 4'd8
    } msg_e;

    typedef enum logic [1:0] {
        OP_LOAD  = 2'd0,
        OP_STORE = 2'd1,
        OP_EVICT = 2'd2
    } cpu_op_e;

    function automatic logic is_transient(input logic [3:0] s);
        return !(s == LS_I || s == LS_S || s == LS_M);
    endfunction

endpackage

// File: rtl/coh_ack_tracker.sv
module coh_ack_tracker #(
    parameter int ACK_W = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    add_en,
    input  logic signed [ACK_W-1:0] add_val,
    input  logic                    dec_en,
    output logic signed [ACK_W-1:0] cnt_q,
    output logic                    zero_next
);
    localparam logic signed [ACK_W-1:0] ONE = ACK_W'(1);

    logic signed [ACK_W-1:0] addend;
    logic signed [ACK_W-1:0] sub;
    logic signed [ACK_W-1:0] cnt_d;

    always_comb begin
        addend    = add_en ? add_val : '0;
        sub       = dec_en ? ONE : '0;
        cnt_d     = cnt_q + addend - sub;
        zero_next = (cnt_d == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               cnt_q <= '0;
        else if (clr)             cnt_q <= '0;
        else if (add_en | dec_en) cnt_q <= cnt_d;
    end
endmodule

// File: rtl/coh_fwd_hold.sv
module coh_fwd_hold #(
    parameter int NODE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic              cap_excl,
    input  logic [NODE_W-1:0] cap_req,
    input  logic              release_i,
    output logic              pend,
    output logic              excl,
    output logic [NODE_W-1:0] req
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend <= 1'b0;
            excl <= 1'b0;
            req  <= '0;
        end else if (release_i) begin
            pend <= 1'b0;
        end else if (capture) begin
            pend <= 1'b1;
            excl <= cap_excl;
            req  <= cap_req;
        end
    end
endmodule

// File: rtl/coh_line_ctrl.sv
module coh_line_ctrl
    import coh_line_pkg::*;
#(
    parameter int NODE_W  = 3,
    parameter int ACK_W   = 4,
    parameter int HOME_ID = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_valid,
    input  logic [1:0]        cpu_op,
    output logic              cpu_hit,
    output logic              cpu_stall,
    input  logic              rx_valid,
    input  logic [3:0]        rx_type,
    input  logic [NODE_W-1:0] rx_src,
    input  logic [ACK_W-1:0]  rx_acks,
    output logic              tx_valid,
    output logic [3:0]        tx_type,
    output logic [NODE_W-1:0] tx_dst,
    output logic              tx_home_copy,
    output logic [3:0]        line_state
);
    localparam logic [NODE_W-1:0] HOME = NODE_W'(HOME_ID);

    line_st_e st_q, st_d;
    msg_e     rmsg;
    cpu_op_e  op;

    logic trk_clr, trk_add, trk_dec, zero_next;
    logic signed [ACK_W-1:0] ack_cnt;
    logic f_cap, f_rel, f_pend, f_excl;
    logic [NODE_W-1:0] f_req;
    msg_e tx_t;

    assign rmsg = msg_e'(rx_type);
    assign op   = cpu_op_e'(cpu_op);

    coh_ack_tracker #(.ACK_W(ACK_W)) u_acks (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (trk_clr),
        .add_en    (trk_add),
        .add_val   (rx_acks),
        .dec_en    (trk_dec),
        .cnt_q     (ack_cnt),
        .zero_next (zero_next)
    );

    coh_fwd_hold #(.NODE_W(NODE_W)) u_fwd (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture   (f_cap),
        .cap_excl  (rmsg == MSG_FWDM),
        .cap_req   (rx_src),
        .release_i (f_rel),
        .pend      (f_pend),
        .excl      (f_excl),
        .req       (f_req)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= LS_I;
        else        st_q <= st_d;
    end

    // next state and outputs
    always_comb begin
        st_d         = st_q;
        cpu_hit      = 1'b0;
        tx_valid     = 1'b0;
        tx_t         = MSG_DATA;
        tx_dst       = HOME;
        tx_home_copy = 1'b0;
        trk_clr      = 1'b0;
        trk_add      = 1'b0;
        trk_dec      = 1'b0;
        f_cap        = 1'b0;
        f_rel        = 1'b0;

        if (rx_valid) begin
            unique case (st_q)
                LS_I: begin
                    if (rmsg == MSG_INV) begin
                        tx_valid = 1'b1; tx_t = MSG_INVACK; tx_dst = rx_src;
                    end
                end
                LS_S: begin
                    if (rmsg == MSG_INV) begin
                        tx_valid = 1'b1; tx_t = MSG_INVACK; tx_dst = rx_src;
                        st_d = LS_I;
                    end
                end
                LS_M: begin
                    if (rmsg == MSG_FWDS) begin
                        tx_valid = 1'b1; tx_dst = rx_src; tx_home_copy = 1'b1;
                        st_d = LS_S;
                    end else if (rmsg == MSG_FWDM) begin
                        tx_valid = 1'b1; tx_dst = rx_src;
                        st_d = LS_I;
                    end
                end
                LS_ISD: begin
                    if (rmsg == MSG_DATA) begin
                        st_d = LS_S;
                    end else if (rmsg == MSG_INV) begin
                        tx_valid = 1'b1; tx_t = MSG_INVACK; tx_dst = rx_src;
                        st_d = LS_ISDI;
                    end
                end
                LS_ISDI: begin
                    if (rmsg == MSG_DATA) st_d = LS_I;
                end
                LS_IMAD, LS_IMA: begin
                    if (rmsg == MSG_DATA && st_q == LS_IMAD) begin
                        trk_add = 1'b1;
                        st_d = zero_next ? (f_pend ? LS_MF : LS_M) : LS_IMA;
                    end else if (rmsg == MSG_INVACK) begin
                        trk_dec = 1'b1;
                        if (st_q == LS_IMA && zero_next)
                            st_d = f_pend ? LS_MF : LS_M;
                    end else if (rmsg == MSG_INV) begin
                        tx_valid = 1'b1; tx_t = MSG_INVACK; tx_dst = rx_src;
                    end else if ((rmsg == MSG_FWDS || rmsg == MSG_FWDM) && !f_pend) begin
                        f_cap = 1'b1;
                    end
                end
                LS_MIA: begin
                    if (rmsg == MSG_FWDS) begin
                        tx_valid = 1'b1; tx_dst = rx_src; tx_home_copy = 1'b1;
                        st_d = LS_SIA;
                    end else if (rmsg == MSG_FWDM) begin
                        tx_valid = 1'b1; tx_dst = rx_src;
                        st_d = LS_IIA;
                    end else if (rmsg == MSG_PUTACK) begin
                        st_d = LS_I;
                    end
                end
                LS_SIA, LS_IIA: begin
                    if (rmsg == MSG_PUTACK) st_d = LS_I;
                end
                default: ;
            endcase
        end else if (cpu_valid) begin
            unique case (st_q)
                LS_I: begin
                    if (op == OP_LOAD) begin
                        tx_valid = 1'b1; tx_t = MSG_GETS; st_d = LS_ISD;
                    end else if (op == OP_STORE) begin
                        tx_valid = 1'b1; tx_t = MSG_GETM; trk_clr = 1'b1;
                        st_d = LS_IMAD;
                    end else if (op == OP_EVICT) begin
                        cpu_hit = 1'b1;
                    end
                end
                LS_S: begin
                    if (op == OP_LOAD) begin
                        cpu_hit = 1'b1;
                    end else if (op == OP_STORE) begin
                        tx_valid = 1'b1; tx_t = MSG_GETM; trk_clr = 1'b1;
                        st_d = LS_IMAD;
                    end else if (op == OP_EVICT) begin
                        cpu_hit = 1'b1; st_d = LS_I;
                    end
                end
                LS_M: begin
                    if (op == OP_LOAD || op == OP_STORE) begin
                        cpu_hit = 1'b1;
                    end else if (op == OP_EVICT) begin
                        tx_valid = 1'b1; tx_t = MSG_PUTM; st_d = LS_MIA;
                    end
                end
                LS_MF: begin
                    if (op == OP_STORE) begin
                        cpu_hit = 1'b1;
                        tx_valid = 1'b1; tx_dst = f_req; tx_home_copy = !f_excl;
                        f_rel = 1'b1;
                        st_d = f_excl ? LS_I : LS_S;
                    end
                end
                default: ;
            endcase
        end
        cpu_stall = cpu_valid & ~cpu_hit;
    end

    assign tx_type    = tx_t;
    assign line_state = st_q;
endmodule

// File: rtl/coh_line_ctrl_chk.sv
module coh_line_ctrl_chk
    import coh_line_pkg::*;
#(
    parameter int NODE_W  = 3,
    parameter int ACK_W   = 4,
    parameter int HOME_ID = 0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_valid,
    input logic [1:0]        cpu_op,
    input logic              cpu_hit,
    input logic              cpu_stall,
    input logic              rx_valid,
    input logic [3:0]        rx_type,
    input logic              tx_valid,
    input logic [3:0]        tx_type,
    input logic [NODE_W-1:0] tx_dst,
    input logic [3:0]        line_state,
    input logic [ACK_W-1:0]  ack_cnt
);
    p_reset_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (line_state == LS_I && !tx_valid));

    p_getm_enters_imad_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_type == MSG_GETM) |-> (tx_dst == NODE_W'(HOME_ID)) ##1 (line_state == LS_IMAD));

    p_full_acks_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (line_state == LS_M && ($past(line_state) == LS_IMAD || $past(line_state) == LS_IMA))
        |-> (ack_cnt == '0));

    p_mf_exit_store_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (line_state != LS_MF && $past(line_state) == LS_MF) |-> $past(cpu_hit));

    p_putm_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_type == MSG_PUTM) |=> (line_state == LS_MIA));

    p_putack_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_type == MSG_PUTACK &&
         (line_state == LS_MIA || line_state == LS_SIA || line_state == LS_IIA)) |=> (line_state == LS_I));

    p_transient_stall_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_valid && is_transient(line_state) && !(line_state == LS_MF && cpu_op == OP_STORE)) |-> !cpu_hit);

    p_rx_first_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> !cpu_hit);

    p_hit_stall_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_hit && cpu_stall));
endmodule

bind coh_line_ctrl coh_line_ctrl_chk #(
    .NODE_W (NODE_W),
    .ACK_W  (ACK_W),
    .HOME_ID(HOME_ID)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_valid  (cpu_valid),
    .cpu_op     (cpu_op),
    .cpu_hit    (cpu_hit),
    .cpu_stall  (cpu_stall),
    .rx_valid   (rx_valid),
    .rx_type    (rx_type),
    .tx_valid   (tx_valid),
    .tx_type    (tx_type),
    .tx_dst     (tx_dst),
    .line_state (line_state),
    .ack_cnt    (ack_cnt)
);

// File: tb/coh_line_ctrl_test.sv
module coh_line_ctrl_test;
    localparam int NODE_W = 3;
    localparam int ACK_W  = 4;
    localparam int HOME   = 0;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cpu_valid = 1'b0;
    logic [1:0] cpu_op = '0;
    logic cpu_hit, cpu_stall;
    logic rx_valid = 1'b0;
    logic [3:0] rx_type = '0;
    logic [NODE_W-1:0] rx_src = '0;
    logic [ACK_W-1:0] rx_acks = '0;
    logic tx_valid, tx_home_copy;
    logic [3:0] tx_type, line_state;
    logic [NODE_W-1:0] tx_dst;

    always #5 clk = ~clk;

    coh_line_ctrl #(.NODE_W(NODE_W), .ACK_W(ACK_W), .HOME_ID(HOME)) uut (
        .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_op(cpu_op),
        .cpu_hit(cpu_hit), .cpu_stall(cpu_stall), .rx_valid(rx_valid),
        .rx_type(rx_type), .rx_src(rx_src), .rx_acks(rx_acks),
        .tx_valid(tx_valid), .tx_type(tx_type), .tx_dst(tx_dst),
        .tx_home_copy(tx_home_copy), .line_state(line_state)
    );

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 0;

    // reference model state
    int m_st = 0;
    int m_cnt = 0;
    bit m_fp = 0;
    int m_fkind = 0;
    int m_freq = 0;

    always @(posedge clk) cycles++;

    initial begin
        wait (cycles > 5000 || done);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish, actual %0d cycles expected fewer", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic step(input string tag, input bit cv, input int op,
                        input bit rv, input int rt, input int src, input int acks);
        int e_hit, e_txv, e_txt, e_dst, e_home, n_st;
        bit ok;
        cpu_valid = cv; cpu_op = 2'(op);
        rx_valid = rv; rx_type = 4'(rt); rx_src = NODE_W'(src); rx_acks = ACK_W'(acks);
        #1;
        e_hit = 0; e_txv = 0; e_txt = 0; e_dst = HOME; e_home = 0; n_st = m_st;
        if (rv) begin
            if (rt == 4) begin
                if (m_st == 0 || m_st == 1 || m_st == 3 || m_st == 5 || m_st == 6) begin
                    e_txv = 1; e_txt = 5; e_dst = src;
                    if (m_st == 1) n_st = 0;
                    if (m_st == 3) n_st = 4;
                end
            end else if (rt == 3) begin
                if (m_st == 3) n_st = 1;
                else if (m_st == 4) n_st = 0;
                else if (m_st == 5) begin
                    m_cnt += acks;
                    n_st = (m_cnt == 0) ? (m_fp ? 7 : 2) : 6;
                end
            end else if (rt == 5) begin
                if (m_st == 5) m_cnt--;
                else if (m_st == 6) begin
                    m_cnt--;
                    if (m_cnt == 0) n_st = m_fp ? 7 : 2;
                end
            end else if (rt == 6 || rt == 7) begin
                if (m_st == 2 || m_st == 8) begin
                    e_txv = 1; e_txt = 3; e_dst = src; e_home = (rt == 6);
                    if (m_st == 2) n_st = (rt == 6) ? 1 : 0;
                    else           n_st = (rt == 6) ? 9 : 10;
                end else if ((m_st == 5 || m_st == 6) && !m_fp) begin
                    m_fp = 1; m_fkind = rt; m_freq = src;
                end
            end else if (rt == 8) begin
                if (m_st == 8 || m_st == 9 || m_st == 10) n_st = 0;
            end
        end else if (cv) begin
            if (op == 0) begin
                if (m_st == 1 || m_st == 2) e_hit = 1;
                else if (m_st == 0) begin e_txv = 1; e_txt = 0; n_st = 3; end
            end else if (op == 1) begin
                if (m_st == 2) e_hit = 1;
                else if (m_st == 0 || m_st == 1) begin
                    e_txv = 1; e_txt = 1; n_st = 5; m_cnt = 0;
                end else if (m_st == 7) begin
                    e_hit = 1; e_txv = 1; e_txt = 3; e_dst = m_freq;
                    e_home = (m_fkind == 6); n_st = (m_fkind == 6) ? 1 : 0; m_fp = 0;
                end
            end else if (op == 2) begin
                if (m_st == 0) e_hit = 1;
                else if (m_st == 1) begin e_hit = 1; n_st = 0; end
                else if (m_st == 2) begin e_txv = 1; e_txt = 2; n_st = 8; end
            end
        end
        ok = (int'(line_state) == m_st) && (int'(cpu_hit) == e_hit) &&
             (int'(cpu_stall) == int'(cv && !e_hit)) && (int'(tx_valid) == e_txv);
        if (e_txv == 1)
            ok = ok && (int'(tx_type) == e_txt) && (int'(tx_dst) == e_dst) &&
                 (int'(tx_home_copy) == e_home);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s (state codes R12): actual st=%0d hit=%0d stall=%0d txv=%0d t=%0d dst=%0d home=%0d expected st=%0d hit=%0d stall=%0d txv=%0d t=%0d dst=%0d home=%0d",
                     tag, line_state, cpu_hit, cpu_stall, tx_valid, tx_type, tx_dst, tx_home_copy,
                     m_st, e_hit, int'(cv && !e_hit), e_txv, e_txt, e_dst, e_home);
        end
        @(posedge clk);
        m_st = n_st;
        @(negedge clk);
    endtask

    task automatic idle(input string tag);
        step(tag, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        idle("R1 reset idle");
        // R2 load miss and fill
        step("R2 load miss Get-S", 1, 0, 0, 0, 0, 0);
        step("R11 load stall IS_D", 1, 0, 0, 0, 0, 0);
        step("R2 fill to S", 0, 0, 1, 3, 0, 0);
        step("R2 load hit in S", 1, 0, 0, 0, 0, 0);
        step("R11 rx beats cpu", 1, 0, 1, 4, 3, 0);   // R10 Inv in S to I
        // R3/R4 store miss with two acks after data
        step("R3 store miss Get-M", 1, 1, 0, 0, 0, 0);
        step("R4 data acks=2", 0, 0, 1, 3, 0, 2);
        step("R11 store stall IM_A", 1, 1, 0, 0, 0, 0);
        step("R4 inv-ack one", 0, 0, 1, 5, 4, 0);
        step("R4 inv-ack last", 0, 0, 1, 5, 5, 0);
        step("R4 store hit in M", 1, 1, 0, 0, 0, 0);
        step("R9 fwd-get-s in M", 0, 0, 1, 6, 2, 0);
        // R4 ack before data: counter goes negative
        step("R3 upgrade from S", 1, 1, 0, 0, 0, 0);
        step("R10 inv in IM_AD", 0, 0, 1, 4, 6, 0);
        step("R4 early inv-ack", 0, 0, 1, 5, 3, 0);
        step("R4 data acks=1", 0, 0, 1, 3, 0, 1);
        step("R2 load hit in M", 1, 0, 0, 0, 0, 0);
        // R6/R7/R8 eviction races
        step("R6 evict M Put-M", 1, 2, 0, 0, 0, 0);
        step("R11 load stall MI_A", 1, 0, 0, 0, 0, 0);
        step("R7 fwd-get-s in MI_A", 0, 0, 1, 6, 5, 0);
        step("R8 put-ack SI_A", 0, 0, 1, 8, 0, 0);
        step("R3 store miss", 1, 1, 0, 0, 0, 0);
        step("R4 data acks=0", 0, 0, 1, 3, 0, 0);
        step("R6 evict M", 1, 2, 0, 0, 0, 0);
        step("R7 fwd-get-m in MI_A", 0, 0, 1, 7, 1, 0);
        step("R11 evict stall II_A", 1, 2, 0, 0, 0, 0);
        step("R8 put-ack II_A", 0, 0, 1, 8, 0, 0);
        step("R6 evict in I", 1, 2, 0, 0, 0, 0);
        step("R3 store miss", 1, 1, 0, 0, 0, 0);
        step("R4 data acks=0", 0, 0, 1, 3, 0, 0);
        step("R6 evict M", 1, 2, 0, 0, 0, 0);
        step("R8 put-ack MI_A", 0, 0, 1, 8, 0, 0);
        // R5 store-store race with exclusive forward
        step("R3 store miss", 1, 1, 0, 0, 0, 0);
        step("R5 fwd-get-m deferred", 1, 1, 1, 7, 1, 0);
        step("R11 store stall IM_AD", 1, 1, 0, 0, 0, 0);
        step("R5 data to MF", 0, 0, 1, 3, 0, 0);
        step("R5 MF waits", 0, 0, 0, 0, 0, 0);
        step("R5 one store then fwd", 1, 1, 0, 0, 0, 0);
        step("R5 back in I", 1, 0, 0, 0, 0, 0);
        // R5 shared forward held, ack outstanding
        step("R2 fill", 0, 0, 1, 3, 0, 0);
        step("R3 upgrade", 1, 1, 0, 0, 0, 0);
        step("R5 fwd-get-s deferred", 0, 0, 1, 6, 4, 0);
        step("R5 data acks=1", 0, 0, 1, 3, 0, 1);
        step("R5 last ack to MF", 0, 0, 1, 5, 2, 0);
        step("R11 load stall MF", 1, 0, 0, 0, 0, 0);
        step("R5 store then shared fwd", 1, 1, 0, 0, 0, 0);
        step("R6 evict in S", 1, 2, 0, 0, 0, 0);
        // R10 invalidation during load miss
        step("R10 inv in I", 0, 0, 1, 4, 2, 0);
        step("R2 load miss", 1, 0, 0, 0, 0, 0);
        step("R10 inv in IS_D", 0, 0, 1, 4, 5, 0);
        step("R10 data in IS_DI", 0, 0, 1, 3, 0, 0);
        step("R10 back in I", 1, 0, 0, 0, 0, 0);
        // R9 exclusive forward in M
        step("R2 fill", 0, 0, 1, 3, 0, 0);
        step("R3 upgrade", 1, 1, 0, 0, 0, 0);
        step("R4 data acks=0", 0, 0, 1, 3, 0, 0);
        step("R9 fwd-get-m in M", 0, 0, 1, 7, 6, 0);
        idle("R9 idle in I");
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule